// File: doc/BRIEF.md
# I2C Host Serial Clock Generator

This block produces the serial clock of an I2C host on an open-drain line. One BAUD field sets both halves of the clock. In the low half the block pulls SCL low for a fixed number of system-clock cycles and then lets it go. The high half is not timed from the moment of release. Its count starts only once the synchronized line has actually been seen high. A slow rising edge, or a target holding the clock low to stretch it, therefore makes the period longer and never eats into the high time. Because the low half is counted from the moment the block starts pulling, the fall time sits inside the low half.

The block also compares the configured low time with the minimum that the selected speed grade allows. It raises a warning flag when the low time is too short, so that firmware can catch a BAUD setting that breaks the bus specification. Start and stop conditions, data shifting, arbitration and the BAUD arithmetic done in software belong to other blocks.

Top module: `scl_clock_gen`

## Requirements
- R1: While `en_i` is 0, `scl_drive_low_o` is 0 and `phase_o` reads 0 (low-phase code), and activity on `scl_in_i` has no effect. When enabled, the block begins with a low phase.
- R2: `scl_drive_low_o` stays 1 for exactly BAUD+5 system-clock cycles, counted from the cycle in which it first rises. It then falls, and `phase_o` changes to 1 (waiting-for-high).
- R3: `scl_in_i` passes through a two-flop synchronizer. `phase_o` stays 1 until the synchronized line reads high, then changes to 2 (high). If the line rises within the first cycle of release, phase 1 lasts 3 cycles.
- R4: Phase 2 lasts exactly BAUD+5 cycles with `scl_drive_low_o` at 0. After that, `phase_o` returns to 0 and `scl_drive_low_o` returns to 1.
- R5: If the line is held low by another device for S extra cycles after release, phase 1 grows to S+3 cycles and phase 2 keeps its full BAUD+5 length.
- R6: With `mode_i` = 0 (standard, 100 kHz grade), `low_viol_o` is 1 exactly when (BAUD+5) times the clock period in ns is below 4700.
- R7: With `mode_i` = 1 (fast, 400 kHz grade), `low_viol_o` is 1 exactly when (BAUD+5) times the period is below 1300.
- R8: With `mode_i` = 2 (fast plus, 1 MHz grade), and with the reserved code 3, `low_viol_o` is 1 exactly when (BAUD+5) times the period is below 500.
- R9: `low_viol_o` depends only on `baud_i` and `mode_i`. It changes in the same cycle as those inputs, whether the block is enabled or not.
- R10: `scl_drive_low_o` is 1 only while `phase_o` is 0 and the block is enabled.
- R11: Dropping `en_i` in the middle of a phase releases SCL at once. The next enable starts a full BAUD+5 low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Run enable; 0 releases SCL and clears the counters |
| baud_i | input | BAUD_W | Shared low and high phase setting |
| mode_i | input | 2 | Speed grade: 0 standard, 1 fast, 2 and 3 fast plus |
| scl_in_i | input | 1 | Sampled level of the SCL line |
| scl_drive_low_o | output | 1 | 1 pulls the open-drain SCL line low |
| phase_o | output | 2 | 0 low, 1 waiting for high, 2 high |
| low_viol_o | output | 1 | Configured low time is under the grade minimum |

## Verification
The hardest situation to create from the ports is a release that the line does not follow: SCL stays low after the block lets go, and the high count must neither start early nor come up short. The bench models the open-drain line itself, as the inverse of the block's pull-down ORed with a second device's pull-down. That second device holds the line for a chosen number of cycles after each release. The bench then counts the waiting and high phases separately. The flag boundaries are reached by choosing BAUD values exactly at, and one below, the smallest legal setting for each grade at the bench clock period.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  typedef enum logic [1:0] {
    PH_LOW       = 2'd0,
    PH_WAIT_HIGH = 2'd1,
    PH_HIGH      = 2'd2
  } scl_phase_e;

  // fixed cycles added to BAUD for both halves of the clock
  localparam int unsigned PHASE_PAD = 5;

  localparam int unsigned TLOW_STD_NS  = 4700;
  localparam int unsigned TLOW_FAST_NS = 1300;
  localparam int unsigned TLOW_FPLS_NS = 500;

  function automatic int unsigned min_low_ns(input logic [1:0] mode);
    case (mode)
      2'd0:    return TLOW_STD_NS;
      2'd1:    return TLOW_FAST_NS;
      default: return TLOW_FPLS_NS;
    endcase
  endfunction

  function automatic int unsigned phase_cycles(input int unsigned baud);
    return baud + PHASE_PAD;
  endfunction

  function automatic logic low_too_short(input int unsigned baud,
                                         input logic [1:0]  mode,
                                         input int unsigned period_ns);
    return (phase_cycles(baud) * period_ns) < min_low_ns(mode);
  endfunction

endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) chain_q <= 1'b1;
        else          chain_q <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) chain_q <= '1;
        else          chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

  // R3: the output only changes after the input has shown the new level
  p_sync_follows_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (q_o != $past(q_o)) |-> (STAGES == 1 || $past(chain_q[STAGES-2]) == q_o));

endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl
  import scl_gen_pkg::*;
#(
  parameter int unsigned BAUD_W = 10,
  parameter int unsigned CNT_W  = BAUD_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              en_i,
  input  logic [BAUD_W-1:0] baud_i,
  input  logic              line_high_i,
  output scl_phase_e        phase_o,
  output logic              low_done_o,
  output logic              high_done_o,
  output logic              high_seen_o
);

  scl_phase_e       phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;
  logic             cnt_at_end;

  // last counter value of a phase: BAUD + PAD - 1
  assign last_cnt   = CNT_W'(baud_i) + CNT_W'(PHASE_PAD - 1);
  assign cnt_at_end = (cnt_q >= last_cnt);

  assign low_done_o  = en_i && (phase_q == PH_LOW)       && cnt_at_end;
  assign high_done_o = en_i && (phase_q == PH_HIGH)      && cnt_at_end;
  assign high_seen_o = en_i && (phase_q == PH_WAIT_HIGH) && line_high_i;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      phase_q <= PH_LOW;
      cnt_q   <= '0;
    end else if (!en_i) begin
      phase_q <= PH_LOW;
      cnt_q   <= '0;
    end else begin
      case (phase_q)
        PH_LOW: begin
          if (low_done_o) begin
            phase_q <= PH_WAIT_HIGH;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_WAIT_HIGH: begin
          cnt_q <= '0;
          if (high_seen_o) phase_q <= PH_HIGH;
        end
        PH_HIGH: begin
          if (high_done_o) begin
            phase_q <= PH_LOW;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          phase_q <= PH_LOW;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  assign phase_o = phase_q;

  // R3: the wait phase holds until the synchronized line is seen high
  p_wait_holds_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (en_i && phase_q == PH_WAIT_HIGH && !line_high_i) |=> (phase_q == PH_WAIT_HIGH));

  // R3: the high phase is entered only from a detected high level
  p_high_needs_line_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (phase_q == PH_WAIT_HIGH) |=> (phase_q != PH_HIGH || $past(line_high_i)));

  // R4: the high phase never falls back into waiting
  p_high_not_wait_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (phase_q == PH_HIGH) |=> (phase_q != PH_WAIT_HIGH));

  // R2: the low phase never skips waiting and goes straight to high
  p_low_not_high_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (phase_q == PH_LOW) |=> (phase_q != PH_HIGH));

  // R1: a disabled controller sits in the low phase with a cleared counter
  p_off_cleared_r1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!en_i) |=> (phase_q == PH_LOW && cnt_q == '0));

endmodule

// File: rtl/scl_lowtime_check.sv
module scl_lowtime_check
  import scl_gen_pkg::*;
#(
  parameter int unsigned BAUD_W    = 10,
  parameter int unsigned PERIOD_NS = 8
) (
  input  logic [BAUD_W-1:0] baud_i,
  input  logic [1:0]        mode_i,
  output logic              viol_o
);

  assign viol_o = low_too_short(32'(baud_i), mode_i, PERIOD_NS);

  // R6: standard mode has the largest minimum, so any violation must break it
  always_comb begin
    if (viol_o) begin
      p_viol_below_std_r6: assert (phase_cycles(32'(baud_i)) * PERIOD_NS < TLOW_STD_NS);
    end
  end

endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen
  import scl_gen_pkg::*;
#(
  parameter int unsigned BAUD_W      = 10,
  parameter int unsigned PERIOD_NS   = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              en_i,
  input  logic [BAUD_W-1:0] baud_i,
  input  logic [1:0]        mode_i,
  input  logic              scl_in_i,
  output logic              scl_drive_low_o,
  output logic [1:0]        phase_o,
  output logic              low_viol_o
);

  localparam int unsigned CNT_W = BAUD_W + 1;

  logic       line_high;
  scl_phase_e phase;
  logic       low_done;
  logic       high_done;
  logic       high_seen;

  scl_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .d_i     (scl_in_i),
    .q_o     (line_high)
  );

  scl_phase_ctrl #(
    .BAUD_W (BAUD_W),
    .CNT_W  (CNT_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_n_i     (rst_n_i),
    .en_i        (en_i),
    .baud_i      (baud_i),
    .line_high_i (line_high),
    .phase_o     (phase),
    .low_done_o  (low_done),
    .high_done_o (high_done),
    .high_seen_o (high_seen)
  );

  scl_lowtime_check #(
    .BAUD_W    (BAUD_W),
    .PERIOD_NS (PERIOD_NS)
  ) u_check (
    .baud_i (baud_i),
    .mode_i (mode_i),
    .viol_o (low_viol_o)
  );

  assign scl_drive_low_o = en_i && (phase == PH_LOW);
  assign phase_o         = phase;

  // R1: nothing pulls the line while disabled
  p_release_off_r1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!en_i) |-> (!scl_drive_low_o));

  // R10: pulling low is confined to the low phase
  p_drive_in_low_r10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    scl_drive_low_o |-> (phase_o == 2'd0));

  // R2: the end of a low phase lets go of the line on the next cycle
  p_release_after_low_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    low_done |=> (!scl_drive_low_o));

  // R4: the end of a high phase pulls the line again if still enabled
  p_pull_after_high_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (high_done && en_i) |=> (phase_o == 2'd0));

  // R3: detection moves straight into the high phase
  p_seen_to_high_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    high_seen |=> (phase_o == 2'd2 || !en_i));

endmodule

// File: tb/scl_clock_gen_test.sv
module scl_clock_gen_test;

  localparam int unsigned PER = 8;

  typedef struct packed {
    logic [1:0] mode;
    logic [9:0] baud;
    logic [7:0] stretch;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{mode: 2'd0, baud: 10'd583, stretch: 8'd0},
    '{mode: 2'd0, baud: 10'd582, stretch: 8'd2},
    '{mode: 2'd1, baud: 10'd158, stretch: 8'd0},
    '{mode: 2'd1, baud: 10'd157, stretch: 8'd5},
    '{mode: 2'd2, baud: 10'd58,  stretch: 8'd1},
    '{mode: 2'd2, baud: 10'd57,  stretch: 8'd0},
    '{mode: 2'd3, baud: 10'd0,   stretch: 8'd3}
  };

  logic       clk = 0;
  logic       rst_n = 0;
  logic       en = 0;
  logic [9:0] baud = 0;
  logic [1:0] mode = 0;
  logic       hold_low = 0;
  logic       drive_low;
  logic [1:0] phase;
  logic       viol;
  logic       scl_line;
  int         total = 0;
  int         bad = 0;
  bit         finished = 0;

  always #4 clk = ~clk;

  assign scl_line = ~(drive_low | hold_low);

  scl_clock_gen uut (
    .clk_i           (clk),
    .rst_n_i         (rst_n),
    .en_i            (en),
    .baud_i          (baud),
    .mode_i          (mode),
    .scl_in_i        (scl_line),
    .scl_drive_low_o (drive_low),
    .phase_o         (phase),
    .low_viol_o      (viol)
  );

  // smallest legal cycle count per grade, rounded up
  function automatic int exp_flag(input int m, input int b);
    int lim;
    int need;
    lim  = (m == 0) ? 4700 : (m == 1) ? 1300 : 500;
    need = (lim + PER - 1) / PER;
    return ((b + 5) < need) ? 1 : 0;
  endfunction

  function automatic string flag_req(input int m);
    return (m == 0) ? "R6" : (m == 1) ? "R7" : "R8";
  endfunction

  task automatic chk(input string req, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  // en is raised at a negedge; counts the sampled cycles of each phase
  task automatic run_cycle(input int b, input int s, input string wreq);
    int low_n;
    int wait_n;
    int high_n;
    int guard;
    low_n = 0; wait_n = 0; high_n = 0; guard = 0;
    @(negedge clk);
    en = 1;
    #1;
    while (phase == 2'd0 && drive_low && guard < 5000) begin
      low_n++; guard++; step();
    end
    chk("R2", low_n, b + 5);
    chk("R2", int'(phase), 1);
    while (phase == 2'd1 && guard < 5000) begin
      hold_low = (wait_n < s);
      wait_n++; guard++; step();
    end
    hold_low = 0;
    chk(wreq, wait_n, s + 3);
    while (phase == 2'd2 && !drive_low && guard < 5000) begin
      high_n++; guard++; step();
    end
    chk("R4", high_n, b + 5);
    chk("R4", int'(drive_low), 1);
    @(negedge clk);
    en = 0;
    #1;
    chk("R11", int'(drive_low), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    // R1: reset state and disabled behaviour
    chk("R1", int'(drive_low), 0);
    chk("R1", int'(phase), 0);
    hold_low = 1;
    repeat (4) step();
    hold_low = 0;
    repeat (4) step();
    chk("R1", int'(phase), 0);
    chk("R1", int'(drive_low), 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      mode = VECS[i].mode;
      baud = VECS[i].baud;
      #1;
      chk(flag_req(int'(VECS[i].mode)), int'(viol),
          exp_flag(int'(VECS[i].mode), int'(VECS[i].baud)));
      run_cycle(int'(VECS[i].baud), int'(VECS[i].stretch),
                (VECS[i].stretch == 0) ? "R3" : "R5");
    end

    // R9: flag tracks inputs while disabled, in the same cycle
    @(negedge clk);
    en = 0; mode = 2'd0; baud = 10'd0;
    #1;
    chk("R9", int'(viol), 1);
    baud = 10'd1000;
    #1;
    chk("R9", int'(viol), 0);
    mode = 2'd2; baud = 10'd57;
    #1;
    chk("R9", int'(viol), exp_flag(2, 57));
    mode = 2'd1; baud = 10'd300;
    #1;
    chk("R7", int'(viol), exp_flag(1, 300));

    // R11: drop enable in mid low phase, then a full low phase follows
    @(negedge clk);
    baud = 10'd10;
    en = 1;
    #1;
    chk("R10", int'(drive_low), 1);
    repeat (4) step();
    en = 0;
    #1;
    chk("R11", int'(drive_low), 0);
    chk("R11", int'(phase), 0);
    repeat (3) step();
    run_cycle(10, 0, "R3");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule